// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides whether a single memory access from a 32-bit core may go ahead. It holds a set of protection entries. Each entry has a configuration byte and an address register, and software writes both through a small write port. Every access presents an address, an access kind (load, store or fetch) and a privilege level. The block answers in the same cycle with an allow flag and a fault cause.

An entry describes its region in one of two ways. In top-of-range mode the region runs from the register below it up to its own register. In naturally-aligned-power-of-two mode the trailing ones of the register give the region's size. The register width sets a coarse granularity, 128 bytes by default. Regions may overlap, and the lowest-numbered entry that matches decides the outcome. A lock bit freezes an entry until reset and makes its permissions bind machine mode as well.

Top module: `pmp_checker`

## Requirements
- R1: After reset, every configuration byte and address register reads as zero. With no entry enabled, a machine-mode (privilege code 3) load is allowed and a user-mode load is denied.
- R2: A configuration or address write lands on the clock edge where its strobe is sampled high. Before that edge the read port still shows the old value. Configuration bits 6:5 always read as zero.
- R3: The address register holds byte-address bits 31:2. With the default granularity, an entry whose mode is not NAPOT reads its low 5 bits as zero. A NAPOT entry reads its low 4 bits as ones. Bits 31:30 of the register read as zero.
- R4: Config layout: bit 0 R, bit 1 W, bit 2 X, bits 4:3 mode (0 off, 1 TOR, 2 NA4, 3 NAPOT), bit 7 lock. A TOR entry matches word addresses from the previous entry's register (inclusive) up to its own (exclusive). Entry 0 uses a base of zero.
- R5: A NAPOT entry whose register is (base | (size/2 − 1)) >> 2 matches exactly the bytes from base to base+size−1. The smallest such region is 128 bytes.
- R6: An entry in mode off, or in mode NA4 (not available at this granularity), never matches.
- R7: When several entries match, only the lowest-numbered one decides the result.
- R8: When no entry matches, machine mode is allowed and privilege codes 0 to 2 are denied.
- R9: When the deciding entry is unlocked, machine mode is allowed whatever its R/W/X bits. Lower privileges are allowed only when the R/W/X bit for the access kind is set.
- R10: When the deciding entry is locked, its R/W/X bits also bind machine mode.
- R11: While an entry's lock bit is set, writes to its configuration and its address register have no effect.
- R12: Access kind codes: 0 load, 1 store, 2 fetch (3 behaves as a load). Fault codes: 0 none (allowed), 1 load fault, 2 store fault, 3 fetch fault. A denied access reports the code for its kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_widx | input | 4 | Entry written by cfg_we |
| cfg_wdata | input | 8 | Configuration byte to write |
| addr_we | input | 1 | Address register write strobe |
| addr_widx | input | 4 | Entry written by addr_we |
| addr_wdata | input | 32 | Address register value (byte address >> 2) |
| rd_idx | input | 4 | Entry shown on the read port |
| cfg_rdata | output | 8 | Configuration byte of entry rd_idx |
| addr_rdata | output | 32 | Address register of entry rd_idx, as seen by software |
| acc_addr | input | 32 | Byte address of the access |
| acc_type | input | 2 | Access kind |
| acc_priv | input | 2 | Privilege level, 3 = machine |
| acc_allow | output | 1 | Access permitted |
| acc_fault | output | 2 | Fault cause |

## Verification
The bench builds the block with its default parameters: 16 entries, a 32-bit address and a granularity exponent of 5. With these values the 128-byte minimum NAPOT region and the 5-bit read-back masking can be checked against hand-computed constants. There are also enough entries for TOR pairs, overlapping NAPOT pairs, an off/NA4 probe and a locked entry to stand in separate slots. Those slots are chosen so that a wrong priority, a mode decoded as the wrong kind, or a lock that fails to hold each flips an observed allow or fault code.

// File: rtl/pmp_checker.sv
`timescale 1ns/1ps
module pmp_checker #(
  parameter int ENTRIES = 16,
  parameter int XLEN    = 32,
  parameter int GRAN    = 5,
  localparam int IW     = $clog2(ENTRIES),
  localparam int AW     = XLEN - 2,
  localparam int SW     = AW - GRAN + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_widx,
  input  logic [7:0]      cfg_wdata,
  input  logic            addr_we,
  input  logic [IW-1:0]   addr_widx,
  input  logic [XLEN-1:0] addr_wdata,
  input  logic [IW-1:0]   rd_idx,
  output logic [7:0]      cfg_rdata,
  output logic [XLEN-1:0] addr_rdata,
  input  logic [XLEN-1:0] acc_addr,
  input  logic [1:0]      acc_type,
  input  logic [1:0]      acc_priv,
  output logic            acc_allow,
  output logic [1:0]      acc_fault
);
  localparam logic [1:0] M_TOR   = 2'd1;
  localparam logic [1:0] M_NAPOT = 2'd3;

  logic [ENTRIES-1:0][7:0]    cfg_q;
  logic [ENTRIES-1:0][SW-1:0] adr_q;
  logic [ENTRIES-1:0][AW-1:0] tor_v;
  logic [ENTRIES-1:0][AW-1:0] nap_v;
  logic [ENTRIES-1:0]         hit;
  logic [AW-1:0]              wa;
  logic [IW-1:0]              sel;
  logic                       any;

  assign wa = acc_addr[AW+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      adr_q <= '0;
    end else begin
      if (cfg_we && !cfg_q[cfg_widx][7])
        cfg_q[cfg_widx] <= cfg_wdata & 8'h9F;
      if (addr_we && !cfg_q[addr_widx][7])
        adr_q[addr_widx] <= addr_wdata[AW-1:GRAN-1];
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [AW-1:0] lo;
    logic [AW-1:0] nmask;
    logic [1:0]    mode;
    assign tor_v[i] = {adr_q[i][SW-1:1], {GRAN{1'b0}}};
    assign nap_v[i] = {adr_q[i], {(GRAN-1){1'b1}}};
    if (i == 0) begin : g_base0
      assign lo = '0;
    end else begin : g_basen
      assign lo = tor_v[i-1];
    end
    assign nmask  = nap_v[i] ^ (nap_v[i] + AW'(1));
    assign mode   = cfg_q[i][4:3];
    assign hit[i] = ((mode == M_TOR) && (wa >= lo) && (wa < tor_v[i])) ||
                    ((mode == M_NAPOT) && (((wa ^ nap_v[i]) & ~nmask) == '0));
  end

  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (hit[k]) begin
        sel = IW'(k);
        any = 1'b1;
      end
    end
  end

  logic [7:0] dcfg;
  logic       machine, perm;
  assign dcfg    = cfg_q[sel];
  assign machine = (acc_priv == 2'd3);
  assign perm    = (acc_type == 2'd1) ? dcfg[1] :
                   (acc_type == 2'd2) ? dcfg[2] : dcfg[0];

  assign acc_allow = any ? ((machine && !dcfg[7]) || perm) : machine;
  assign acc_fault = acc_allow ? 2'd0 :
                     (acc_type == 2'd1) ? 2'd2 :
                     (acc_type == 2'd2) ? 2'd3 : 2'd1;

  assign cfg_rdata  = cfg_q[rd_idx];
  assign addr_rdata = XLEN'((cfg_q[rd_idx][4:3] == M_NAPOT) ? nap_v[rd_idx] : tor_v[rd_idx]);
endmodule

// File: rtl/pmp_checker_sva.sv
`timescale 1ns/1ps
module pmp_checker_sva #(
  parameter int ENTRIES = 16,
  localparam int IW     = $clog2(ENTRIES)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we,
  input logic [IW-1:0]            cfg_widx,
  input logic [7:0]               cfg_wdata,
  input logic [IW-1:0]            rd_idx,
  input logic [7:0]               cfg_rdata,
  input logic [1:0]               acc_type,
  input logic [1:0]               acc_priv,
  input logic                     acc_allow,
  input logic [1:0]               acc_fault,
  input logic [ENTRIES-1:0][7:0]  cfg_q
);
  logic none_on;
  always_comb begin
    none_on = 1'b1;
    for (int k = 0; k < ENTRIES; k++)
      if (cfg_q[k][4:3] != 2'd0) none_on = 1'b0;
  end

  // R12
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_allow |-> acc_fault == 2'd0);
  // R12
  fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_allow |-> acc_fault != 2'd0);
  // R12
  store_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_allow && acc_type == 2'd1) |-> acc_fault == 2'd2);
  // R8
  machine_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (none_on && acc_priv == 2'd3) |-> acc_allow);
  // R8
  user_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (none_on && acc_priv != 2'd3) |-> !acc_allow);
  // R11
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_widx == rd_idx && cfg_rdata[7]) |=> ($stable(rd_idx) -> $stable(cfg_rdata)));
  // R2
  cfg_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_widx == rd_idx && !cfg_rdata[7]) |=>
      ($stable(rd_idx) -> cfg_rdata == ($past(cfg_wdata) & 8'h9F)));
endmodule

bind pmp_checker pmp_checker_sva #(.ENTRIES(ENTRIES)) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_widx(cfg_widx),
  .cfg_wdata(cfg_wdata), .rd_idx(rd_idx), .cfg_rdata(cfg_rdata),
  .acc_type(acc_type), .acc_priv(acc_priv), .acc_allow(acc_allow),
  .acc_fault(acc_fault), .cfg_q(cfg_q)
);

// File: tb/test_pmp_checker.sv
`timescale 1ns/1ps
module test_pmp_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, addr_we = 1'b0;
  logic [3:0]  cfg_widx = '0, addr_widx = '0, rd_idx = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [31:0] addr_wdata = '0, acc_addr = '0;
  logic [1:0]  acc_type = '0, acc_priv = '0;
  logic [7:0]  cfg_rdata;
  logic [31:0] addr_rdata;
  logic        acc_allow;
  logic [1:0]  acc_fault;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pmp_checker i_pmp_checker (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_widx(cfg_widx), .cfg_wdata(cfg_wdata),
    .addr_we(addr_we), .addr_widx(addr_widx), .addr_wdata(addr_wdata), .rd_idx(rd_idx),
    .cfg_rdata(cfg_rdata), .addr_rdata(addr_rdata), .acc_addr(acc_addr), .acc_type(acc_type),
    .acc_priv(acc_priv), .acc_allow(acc_allow), .acc_fault(acc_fault)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wcfg(input int idx, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_widx = 4'(idx); cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic waddr(input int idx, input logic [31:0] d);
    @(negedge clk); addr_we = 1'b1; addr_widx = 4'(idx); addr_wdata = d;
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic rd(input int idx);
    @(negedge clk); rd_idx = 4'(idx); #2;
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] t, input logic [1:0] p,
                     input logic ea, input logic [1:0] ef, input string tag);
    @(negedge clk); acc_addr = a; acc_type = t; acc_priv = p; #2;
    chk({31'd0, acc_allow}, {31'd0, ea}, {tag, " allow"});
    chk({30'd0, acc_fault}, {30'd0, ef}, {tag, " fault"});
  endtask

  task automatic t_reset;
    rd(0);  chk(cfg_rdata, 0, "R1 cfg0");  chk(addr_rdata, 0, "R1 addr0");
    rd(15); chk(cfg_rdata, 0, "R1 cfg15"); chk(addr_rdata, 0, "R1 addr15");
    acc(32'h1234_0000, 2'd0, 2'd3, 1'b1, 2'd0, "R1 machine load");
    acc(32'h1234_0000, 2'd0, 2'd0, 1'b0, 2'd1, "R1 user load");
  endtask

  task automatic t_write_timing;
    @(negedge clk); rd_idx = 4'd5; cfg_we = 1'b1; cfg_widx = 4'd5; cfg_wdata = 8'h6B; #2;
    chk(cfg_rdata, 8'h00, "R2 before edge");
    @(negedge clk); cfg_we = 1'b0; #2;
    chk(cfg_rdata, 8'h0B, "R2 after edge, reserved bits cleared");
    wcfg(5, 8'h00);
  endtask

  task automatic t_gran;
    waddr(2, 32'hFFFF_FFFF);
    rd(2); chk(addr_rdata, 32'h3FFF_FFE0, "R3 off readback");
    wcfg(2, 8'h18);
    rd(2); chk(addr_rdata, 32'h3FFF_FFFF, "R3 napot readback");
    wcfg(2, 8'h00); waddr(2, 32'h0);
  endtask

  task automatic t_tor;
    waddr(0, 32'h0000_0400); wcfg(0, 8'h09);
    waddr(1, 32'h0000_0800); wcfg(1, 8'h0B);
    acc(32'h0000_0000, 2'd0, 2'd0, 1'b1, 2'd0, "R4 base zero");
    acc(32'h0000_0FFC, 2'd0, 2'd0, 1'b1, 2'd0, "R4 top of e0");
    acc(32'h0000_0FFC, 2'd1, 2'd0, 1'b0, 2'd2, "R4 e0 store");
    acc(32'h0000_1000, 2'd1, 2'd0, 1'b1, 2'd0, "R4 e1 lower bound");
    acc(32'h0000_1FFC, 2'd1, 2'd0, 1'b1, 2'd0, "R4 e1 top");
    acc(32'h0000_2000, 2'd0, 2'd0, 1'b0, 2'd1, "R4 e1 exclusive end");
    acc(32'h0000_1000, 2'd2, 2'd0, 1'b0, 2'd3, "R12 fetch fault");
  endtask

  task automatic t_napot;
    waddr(3, 32'h0000_21FF); wcfg(3, 8'h1D);
    rd(3); chk(addr_rdata, 32'h0000_21FF, "R5 readback");
    acc(32'h0000_8000, 2'd2, 2'd0, 1'b1, 2'd0, "R5 base");
    acc(32'h0000_8FFC, 2'd2, 2'd0, 1'b1, 2'd0, "R5 last word");
    acc(32'h0000_9000, 2'd2, 2'd0, 1'b0, 2'd3, "R5 past end");
    acc(32'h0000_7FFC, 2'd2, 2'd0, 1'b0, 2'd3, "R5 below base");
    acc(32'h0000_8800, 2'd1, 2'd0, 1'b0, 2'd2, "R5 store no W");
    waddr(4, 32'h0000_280F); wcfg(4, 8'h19);
    acc(32'h0000_A07C, 2'd3, 2'd0, 1'b1, 2'd0, "R5 128B last, R12 code3 as load");
    acc(32'h0000_A080, 2'd0, 2'd0, 1'b0, 2'd1, "R5 128B end");
  endtask

  task automatic t_off;
    waddr(6, 32'h0001_0000); wcfg(6, 8'h07);
    acc(32'h0003_0000, 2'd0, 2'd0, 1'b0, 2'd1, "R6 off entry");
    waddr(6, 32'h0000_C000); wcfg(6, 8'h17);
    acc(32'h0003_0000, 2'd0, 2'd0, 1'b0, 2'd1, "R6 na4 entry");
    wcfg(6, 8'h00); waddr(6, 32'h0);
  endtask

  task automatic t_prio;
    waddr(8, 32'h0001_1FFF); wcfg(8, 8'h19);
    waddr(9, 32'h0001_3FFF); wcfg(9, 8'h1B);
    acc(32'h0004_1000, 2'd1, 2'd0, 1'b0, 2'd2, "R7 low index wins");
    acc(32'h0004_1000, 2'd0, 2'd0, 1'b1, 2'd0, "R7 low index read");
    acc(32'h0005_4000, 2'd1, 2'd0, 1'b1, 2'd0, "R7 only high index");
  endtask

  task automatic t_nomatch;
    acc(32'h7000_0000, 2'd0, 2'd3, 1'b1, 2'd0, "R8 machine");
    acc(32'h7000_0000, 2'd2, 2'd0, 1'b0, 2'd3, "R8 user fetch");
    acc(32'h7000_0000, 2'd1, 2'd1, 1'b0, 2'd2, "R8 supervisor store");
  endtask

  task automatic t_unlocked;
    acc(32'h0000_8000, 2'd1, 2'd3, 1'b1, 2'd0, "R9 machine store on RX");
    acc(32'h0000_0FFC, 2'd2, 2'd3, 1'b1, 2'd0, "R9 machine fetch on R");
  endtask

  task automatic t_locked;
    wcfg(3, 8'h9D);
    acc(32'h0000_8000, 2'd1, 2'd3, 1'b0, 2'd2, "R10 machine store");
    acc(32'h0000_8000, 2'd2, 2'd3, 1'b1, 2'd0, "R10 machine fetch");
    acc(32'h0000_8000, 2'd0, 2'd3, 1'b1, 2'd0, "R10 machine load");
  endtask

  task automatic t_lock_ignore;
    wcfg(3, 8'h1F);
    waddr(3, 32'h0);
    rd(3);
    chk(cfg_rdata, 8'h9D, "R11 cfg kept");
    chk(addr_rdata, 32'h0000_21FF, "R11 addr kept");
    acc(32'h0000_8000, 2'd1, 2'd3, 1'b0, 2'd2, "R11 still denied");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_timing();
    t_gran();
    t_tor();
    t_napot();
    t_off();
    t_prio();
    t_nomatch();
    t_unlocked();
    t_locked();
    t_lock_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule